// File: doc/BRIEF.md
# Byte-to-Word Assembler with Sync Flush

This block sits behind a serial link receiver and turns a stream of 8-bit bytes into 32-bit words. Each byte arrives with a data strobe. Four accepted bytes fill a holding row, one slot per byte, and the row is then copied to registered outputs with a one-cycle valid pulse. A four-state slot machine picks the slot that each strobe writes. Its states are `SL_0`, `SL_1`, `SL_2` and `SL_3`. An accepted strobe moves it to the next state, and the move `SL_3 -> SL_0` completes a word.

Command symbols are 4 bits wide and arrive on their own strobe. A symbol with bit 0 set is a sync. A sync sends the slot machine to `SL_0` from any state. If the row holds one to three bytes, the sync flushes them to the outputs. Any other command symbol takes up a slot the same way a byte does, and its nibble goes into a command holding row that loads together with the data row.

A second state machine decides whether an output load happens. Its states are:
- `LD_IDLE`: no load is due.
- `LD_FULL`: a word was completed, so a load follows.
- `LD_FLUSH`: a sync found a partial row, so a load follows.
- `LD_HOLD`: a sync found an empty row, so no load follows.

Each cycle this machine goes to one of those states:
- `LD_FLUSH` on a sync with the slot machine not in `SL_0`.
- `LD_HOLD` on a sync in `SL_0`.
- `LD_FULL` on an accepted strobe in `SL_3`.
- `LD_IDLE` otherwise.

The output registers load on the clock edge that ends a cycle spent in `LD_FULL` or `LD_FLUSH`.

Top module: `word_asm`

## Requirements
- R1: While `rst` is high at a rising edge, all registers are cleared: after that edge `word_out`, `cmd_out` and `word_vld` are zero and the next accepted strobe fills slot 0.
- R2: The k-th accepted slot of a word (k = 0..3, in arrival order) appears at `word_out[8k+7:8k]`.
- R3: When the fourth slot is accepted at rising edge E, `word_out` shows the completed word and `word_vld` is high after edge E+1.
- R4: A sync is `cmd_stb` high with `cmd_sym[0]` = 1. The slot after a sync is slot 0, whatever the slot count was before.
- R5: A sync sampled at edge E while one to three slots are held loads those slots at edge E+1 with `word_vld` high, and the slots not written read as zero.
- R6: A sync sampled while no slot is held gives no load, and a full-word load already due still takes place on time.
- R7: While syncs repeat on consecutive cycles, `word_out` and `cmd_out` stay unchanged and `word_vld` stays low after any flush that the first sync caused.
- R8: If `dat_stb` and a sync arrive in the same cycle, the byte is discarded and no slot is taken.
- R9: A non-sync command (`cmd_stb` high, `cmd_sym[0]` = 0) takes one slot. Its nibble appears at `cmd_out[4k+3:4k]` and the data byte of that slot reads zero. If `dat_stb` is high in the same cycle, both values go into that one slot.
- R10: `word_vld` is high for exactly one cycle per load and never in two consecutive cycles.
- R11: The holding rows are cleared by each load. A strobe accepted on the load edge itself becomes slot 0 of the next word, and the slots of the next word that are not written read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver clock |
| rst | input | 1 | Synchronous active-high reset |
| dat_stb | input | 1 | Data byte strobe |
| dat_byte | input | 8 | Received data byte |
| cmd_stb | input | 1 | Command symbol strobe |
| cmd_sym | input | 4 | Command symbol; bit 0 set marks a sync |
| word_out | output | 32 | Assembled data word, slot k at bits 8k+7:8k |
| cmd_out | output | 16 | Command nibbles, slot k at bits 4k+3:4k |
| word_vld | output | 1 | One-cycle pulse when the outputs load |

## Verification
Two functions can fall in the same cycle here.

- **Sync and a data strobe together.** The bench drives `dat_stb` and a sync in the same cycle, once with a partial row and once in `SL_3`. It judges the result by the flushed word, which must not contain the discarded byte, and by the next full word, which must start in slot 0.
- **A load and a new strobe together.** The bench puts a byte on the very edge where a flush or full-word load happens. It checks that the flushed word excludes that byte, and that the byte opens the next word with the other slots cleared.

A sync that arrives one cycle after a word completes is also driven, to confirm that the load already due is neither lost nor duplicated.

// File: rtl/wasm_pkg.sv
package wasm_pkg;

    localparam int SLOTS = 4;

    typedef enum logic [1:0] {
        SL_0 = 2'd0,
        SL_1 = 2'd1,
        SL_2 = 2'd2,
        SL_3 = 2'd3
    } slot_e;

    typedef enum logic [1:0] {
        LD_IDLE  = 2'd0,
        LD_FULL  = 2'd1,
        LD_FLUSH = 2'd2,
        LD_HOLD  = 2'd3
    } load_e;

endpackage

// File: rtl/wasm_slot_fsm.sv
module wasm_slot_fsm
    import wasm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fill,
    input  logic             sync,
    output logic [SLOTS-1:0] slot_en,
    output logic             load
);

    slot_e slot_q, slot_d;
    load_e ld_q, ld_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= SL_0;
            ld_q   <= LD_IDLE;
        end else begin
            slot_q <= slot_d;
            ld_q   <= ld_d;
        end
    end

    // transitions: sync outranks fill
    always_comb begin
        slot_d = slot_q;
        ld_d   = LD_IDLE;
        if (sync) begin
            slot_d = SL_0;
            ld_d   = (slot_q == SL_0) ? LD_HOLD : LD_FLUSH;
        end else if (fill) begin
            unique case (slot_q)
                SL_0: slot_d = SL_1;
                SL_1: slot_d = SL_2;
                SL_2: slot_d = SL_3;
                SL_3: begin
                    slot_d = SL_0;
                    ld_d   = LD_FULL;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        slot_en = '0;
        if (fill && !sync) begin
            slot_en[int'(slot_q)] = 1'b1;
        end
        unique case (ld_q)
            LD_FULL, LD_FLUSH: load = 1'b1;
            LD_IDLE, LD_HOLD:  load = 1'b0;
        endcase
    end

endmodule

// File: rtl/wasm_hold_row.sv
module wasm_hold_row #(
    parameter  int W     = 8,
    parameter  int SLOTS = 4,
    localparam int ROW_W = W * SLOTS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [SLOTS-1:0] wr_en,
    input  logic [W-1:0]     wr_data,
    output logic [ROW_W-1:0] row
);

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        logic [W-1:0] cell_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                cell_q <= '0;
            end else if (wr_en[k]) begin
                cell_q <= wr_data;
            end else if (clr) begin
                cell_q <= '0;
            end
        end

        assign row[k*W +: W] = cell_q;
    end

endmodule

// File: rtl/wasm_out_reg.sv
module wasm_out_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/word_asm.sv
module word_asm #(
    parameter  int BYTE_W = 8,
    parameter  bit CMD_EN = 1'b1,
    localparam int SLOTS  = wasm_pkg::SLOTS,
    localparam int CMD_W  = BYTE_W / 2,
    localparam int WORD_W = BYTE_W * SLOTS,
    localparam int CROW_W = CMD_W * SLOTS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dat_stb,
    input  logic [BYTE_W-1:0] dat_byte,
    input  logic              cmd_stb,
    input  logic [CMD_W-1:0]  cmd_sym,
    output logic [WORD_W-1:0] word_out,
    output logic [CROW_W-1:0] cmd_out,
    output logic              word_vld
);

    logic             sync_det;
    logic             cmd_fill;
    logic             fill;
    logic             load;
    logic [SLOTS-1:0] slot_en;
    logic [WORD_W-1:0] data_row;

    assign sync_det = cmd_stb & cmd_sym[0];
    assign cmd_fill = CMD_EN & cmd_stb & ~cmd_sym[0];
    assign fill     = dat_stb | cmd_fill;

    wasm_slot_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .fill    (fill),
        .sync    (sync_det),
        .slot_en (slot_en),
        .load    (load)
    );

    wasm_hold_row #(.W(BYTE_W), .SLOTS(SLOTS)) u_drow (
        .clk     (clk),
        .rst     (rst),
        .clr     (load),
        .wr_en   (slot_en & {SLOTS{dat_stb}}),
        .wr_data (dat_byte),
        .row     (data_row)
    );

    wasm_out_reg #(.W(WORD_W)) u_dout (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .d    (data_row),
        .q    (word_out)
    );

    if (CMD_EN) begin : g_cmd
        logic [CROW_W-1:0] cmd_row;

        wasm_hold_row #(.W(CMD_W), .SLOTS(SLOTS)) u_crow (
            .clk     (clk),
            .rst     (rst),
            .clr     (load),
            .wr_en   (slot_en & {SLOTS{cmd_fill}}),
            .wr_data (cmd_sym),
            .row     (cmd_row)
        );

        wasm_out_reg #(.W(CROW_W)) u_cout (
            .clk  (clk),
            .rst  (rst),
            .load (load),
            .d    (cmd_row),
            .q    (cmd_out)
        );
    end else begin : g_nocmd
        assign cmd_out = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_vld <= 1'b0;
        end else begin
            word_vld <= load;
        end
    end

endmodule

// File: rtl/word_asm_chk.sv
module word_asm_chk #(
    parameter int WORD_W = 32,
    parameter int SLOTS  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              sync_det,
    input logic [SLOTS-1:0]  slot_en,
    input logic              load,
    input logic [WORD_W-1:0] word_out,
    input logic              word_vld
);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!word_vld && word_out == '0));

    p_load_to_valid_r3: assert property (@(posedge clk) disable iff (rst)
        load |=> word_vld);

    p_slot_restart_r4: assert property (@(posedge clk) disable iff (rst)
        sync_det |=> (slot_en == '0 || slot_en[0]));

    p_sync_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (sync_det && $past(sync_det)) |=> ##1 (!word_vld && $stable(word_out)));

    p_sync_wins_r8: assert property (@(posedge clk) disable iff (rst)
        sync_det |-> (slot_en == '0));

    p_no_spurious_r10: assert property (@(posedge clk) disable iff (rst)
        !load |=> !word_vld);

    p_single_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        word_vld |=> !word_vld);

    p_one_slot_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(slot_en));

endmodule

bind word_asm word_asm_chk #(.WORD_W(WORD_W), .SLOTS(SLOTS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .sync_det (sync_det),
    .slot_en  (slot_en),
    .load     (load),
    .word_out (word_out),
    .word_vld (word_vld)
);

// File: tb/sim_word_asm.sv
`timescale 1ns/1ps
module sim_word_asm;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dat_stb = 1'b0;
    logic [7:0]  dat_byte = '0;
    logic        cmd_stb = 1'b0;
    logic [3:0]  cmd_sym = '0;
    logic [31:0] word_out;
    logic [15:0] cmd_out;
    logic        word_vld;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    word_asm u0 (
        .clk      (clk),
        .rst      (rst),
        .dat_stb  (dat_stb),
        .dat_byte (dat_byte),
        .cmd_stb  (cmd_stb),
        .cmd_sym  (cmd_sym),
        .word_out (word_out),
        .cmd_out  (cmd_out),
        .word_vld (word_vld)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // one clock cycle with the given inputs, returns at the following negedge
    task automatic cyc(input logic ds, input logic [7:0] b, input logic cs, input logic [3:0] s);
        dat_stb  = ds;
        dat_byte = b;
        cmd_stb  = cs;
        cmd_sym  = s;
        @(negedge clk);
    endtask

    task automatic idle();
        cyc(1'b0, 8'h00, 1'b0, 4'h0);
    endtask

    task automatic sync_sym(input logic [3:0] s);
        cyc(1'b0, 8'h00, 1'b1, s | 4'h1);
    endtask

    function automatic logic [7:0] pat(input int w, input int k);
        return 8'((w * 37 + k * 11 + 5) & 255);
    endfunction

    function automatic logic [31:0] partial(input logic [31:0] full, input int n);
        logic [31:0] m;
        m = (n >= 4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * n)) - 32'h1);
        return full & m;
    endfunction

    initial begin
        logic [31:0] exp_w;
        logic [31:0] held;
        logic [7:0]  b;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 word_out", word_out, 32'h0);
        check("R1 cmd_out", {16'h0, cmd_out}, 32'h0);
        check("R1 word_vld", {31'h0, word_vld}, 32'h0);

        // R2 R3 R10: full words with varied spacing
        for (int w = 0; w < 16; w++) begin
            exp_w = '0;
            for (int k = 0; k < 4; k++) begin
                b = pat(w, k);
                exp_w[8*k +: 8] = b;
                cyc(1'b1, b, 1'b0, 4'h0);
                if (k < 3) repeat (w % 3) idle();
            end
            idle();
            check("R3 valid after fourth slot", {31'h0, word_vld}, 32'h1);
            check("R2 word layout", word_out, exp_w);
            check("R11 cmd row clear", {16'h0, cmd_out}, 32'h0);
            idle();
            check("R10 single pulse", {31'h0, word_vld}, 32'h0);
        end

        // R4 R5 R6: sync after 0..3 bytes, then a fresh word
        for (int n = 0; n < 4; n++) begin
            held = word_out;
            exp_w = '0;
            for (int k = 0; k < n; k++) begin
                b = pat(n + 40, k);
                exp_w[8*k +: 8] = b;
                cyc(1'b1, b, 1'b0, 4'h0);
            end
            sync_sym(4'(2 * n));
            idle();
            if (n > 0) begin
                check("R5 flush valid", {31'h0, word_vld}, 32'h1);
                check("R5 flush word zero fill", word_out, partial(exp_w, n));
            end else begin
                check("R6 empty sync no valid", {31'h0, word_vld}, 32'h0);
                check("R6 empty sync word kept", word_out, held);
            end
            idle();
            exp_w = '0;
            for (int k = 0; k < 4; k++) begin
                b = pat(n + 60, k);
                exp_w[8*k +: 8] = b;
                cyc(1'b1, b, 1'b0, 4'h0);
            end
            idle();
            check("R4 slot restart", word_out, exp_w);
            check("R4 slot restart valid", {31'h0, word_vld}, 32'h1);
        end

        // R6: sync on the cycle right after the fourth byte
        exp_w = '0;
        for (int k = 0; k < 4; k++) begin
            b = pat(70, k);
            exp_w[8*k +: 8] = b;
            cyc(1'b1, b, 1'b0, 4'h0);
        end
        sync_sym(4'h1);
        check("R6 pending full load kept", {31'h0, word_vld}, 32'h1);
        check("R6 pending full word", word_out, exp_w);
        idle();
        check("R6 no extra load", {31'h0, word_vld}, 32'h0);
        idle();
        check("R6 word stable", word_out, exp_w);

        // R7: repeated syncs after a partial row
        cyc(1'b1, 8'h5A, 1'b0, 4'h0);
        cyc(1'b1, 8'hC3, 1'b0, 4'h0);
        sync_sym(4'h1);
        sync_sym(4'h3);
        check("R7 first flush valid", {31'h0, word_vld}, 32'h1);
        check("R7 first flush word", word_out, 32'h0000_C35A);
        sync_sym(4'h5);
        check("R7 no valid while held", {31'h0, word_vld}, 32'h0);
        sync_sym(4'hF);
        check("R7 word unchanged", word_out, 32'h0000_C35A);
        check("R7 no valid later", {31'h0, word_vld}, 32'h0);
        idle();
        idle();
        check("R7 word unchanged after", word_out, 32'h0000_C35A);
        check("R7 valid low after", {31'h0, word_vld}, 32'h0);

        // R8: data strobe with sync in the same cycle
        cyc(1'b1, 8'h11, 1'b0, 4'h0);
        cyc(1'b1, 8'hEE, 1'b1, 4'h1);
        idle();
        check("R8 byte discarded in flush", word_out, 32'h0000_0011);
        for (int k = 0; k < 4; k++) cyc(1'b1, 8'(8'h21 + k), 1'b0, 4'h0);
        idle();
        check("R8 next word from slot 0", word_out, 32'h2423_2221);

        // R8 again, sync and strobe while in the last slot
        for (int k = 0; k < 3; k++) cyc(1'b1, 8'(8'h31 + k), 1'b0, 4'h0);
        cyc(1'b1, 8'hFF, 1'b1, 4'h7);
        idle();
        check("R8 last slot strobe discarded", word_out, 32'h0033_3231);

        // R9: command nibbles share slots with bytes
        cyc(1'b0, 8'h00, 1'b1, 4'h6);
        cyc(1'b1, 8'h71, 1'b0, 4'h0);
        cyc(1'b1, 8'h72, 1'b1, 4'hA);
        cyc(1'b1, 8'h73, 1'b0, 4'h0);
        idle();
        check("R9 command word valid", {31'h0, word_vld}, 32'h1);
        check("R9 data bytes", word_out, 32'h7372_7100);
        check("R9 command nibbles", {16'h0, cmd_out}, 32'h0000_0A06);

        // R11: byte accepted on the flush edge opens the next word
        for (int k = 0; k < 3; k++) cyc(1'b1, 8'(8'h81 + k), 1'b0, 4'h0);
        sync_sym(4'h1);
        cyc(1'b1, 8'h90, 1'b0, 4'h0);
        check("R11 flush on load edge valid", {31'h0, word_vld}, 32'h1);
        check("R11 flush excludes new byte", word_out, 32'h0083_8281);
        check("R11 command row cleared", {16'h0, cmd_out}, 32'h0);
        for (int k = 1; k < 4; k++) cyc(1'b1, 8'(8'h90 + k), 1'b0, 4'h0);
        idle();
        check("R11 new word from load edge", word_out, 32'h9392_9190);

        // R11: partial flush after a full word clears old bytes
        cyc(1'b1, 8'hA5, 1'b0, 4'h0);
        sync_sym(4'h1);
        idle();
        check("R11 stale slots zero", word_out, 32'h0000_00A5);

        // R1: reset mid-word
        cyc(1'b1, 8'hB1, 1'b0, 4'h0);
        rst = 1'b1;
        idle();
        rst = 1'b0;
        check("R1 reset clears word", word_out, 32'h0);
        for (int k = 0; k < 4; k++) cyc(1'b1, 8'(8'hC0 + k), 1'b0, 4'h0);
        idle();
        check("R1 slot 0 after reset", word_out, 32'hC3C2_C1C0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule